// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between an on-chip request port and an external asynchronous static RAM of 32K bytes with active-low chip select, write strobe and output enable. A client offers one read or one write at a time with a valid/ready handshake; the block then plays out the pin sequence the memory needs, holding every phase for a whole number of clock cycles. Read data comes back on a separate response port marked by a one-cycle valid pulse.

Every pin is driven from a flop, so pins move only on clock edges. The length of each phase is worked out at elaboration from the memory's speed figures in nanoseconds and the clock period in nanoseconds, always rounding up. Writes are strobe-timed (the write strobe defines the write window, output enable stays high); reads hold chip select and output enable low for the whole access. Because the memory keeps driving its data pins for a while after output enable rises, a write that follows a read waits a number of quiet cycles before the block turns its own data drivers on.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and straight after reset, `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: From the edge that accepts a write (with no turnaround owed), the pins show the request's address on `mem_addr` and data on `mem_dq_out` with `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1, `mem_dq_oe`=1, and `mem_we_n` stays 0 for exactly WP cycles.
- R3: From the edge that accepts a read, `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for exactly ACC cycles; `mem_dq_in` is sampled at the edge ending that window and appears on `rsp_rdata` while `rsp_valid` is 1 for exactly one cycle.
- R4: Cycle counts are ceil(ns / CLK_NS), at least 1: ACC from ACCESS_NS, TA from RELEASE_NS, CYC from CYCLE_NS, and WP the larger of the counts from WR_PULSE_NS and DATA_SETUP_NS.
- R5: `req_ready` falls at the accepting edge and stays 0 for TA' + max(phase, CYC) cycles, where phase is WP or ACC and TA' is the turnaround of R6 (else 0).
- R6: A write accepted when the previous completed operation was a read first spends TA cycles with all three enables at 1 and `mem_dq_oe`=0, then performs the R2 sequence.
- R7: A request offered while `req_ready` is 0 is ignored: it causes no write strobe and leaves memory content unchanged.
- R8: `mem_we_n` and `mem_oe_n` are never 0 together, and `mem_dq_oe` is 1 only while `mem_ce_n` and `mem_we_n` are both 0.
- R9: Whenever `mem_ce_n` is 1, `mem_we_n` and `mem_oe_n` are 1; between operations all three are 1.
- R10: A read needs no turnaround: it starts at its accepting edge even right after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 15 | Address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data towards the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The bench runs the block with slow timing figures so every phase spans several cycles, against a memory model that returns junk until the access count has elapsed and keeps driving for the release time after output enable rises. Write-then-read pairs tell apart correct strobe length and address latching; read-then-write pairs separate an honoured turnaround from bus contention; read-after-read and write-after-write show that no turnaround is wrongly inserted. Requests held valid during a busy period, aimed at a neighbouring address, show whether the handshake really blocks them, and the highest and lowest addresses exercise the full address width.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_WRITE = 3'd2,
    ST_READ  = 3'd3,
    ST_PAD   = 3'd4
  } seq_state_t;

  // Rounded-up conversion of a time in ns to clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Filler cycles needed so that a phase of 'phase' cycles meets a cycle floor 'cyc'.
  function automatic int unsigned pad_cyc(input int unsigned phase, input int unsigned cyc);
    return (cyc > phase) ? (cyc - phase) : 0;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign done = (remain == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned WP_CYC  = 1,
  parameter int unsigned ACC_CYC = 1,
  parameter int unsigned TA_CYC  = 1,
  parameter int unsigned CYC_CYC = 1,
  parameter int unsigned CW      = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_done,
  output logic          ready,
  output logic          accept,
  output logic          cap_fire,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output seq_state_t    state_nxt
);

  localparam int unsigned WR_PAD = pad_cyc(WP_CYC, CYC_CYC);
  localparam int unsigned RD_PAD = pad_cyc(ACC_CYC, CYC_CYC);

  localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] ACC_LD = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] TA_LD  = CW'(TA_CYC - 1);
  localparam logic [CW-1:0] WRP_LD = CW'((WR_PAD > 0) ? WR_PAD - 1 : 0);
  localparam logic [CW-1:0] RDP_LD = CW'((RD_PAD > 0) ? RD_PAD - 1 : 0);

  seq_state_t state;
  logic       owe_turn;

  assign ready  = (state == ST_IDLE);
  assign accept = ready && req_valid;

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    cap_fire  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write && owe_turn) begin
            state_nxt = ST_TURN;
            tmr_val   = TA_LD;
          end else if (req_write) begin
            state_nxt = ST_WRITE;
            tmr_val   = WP_LD;
          end else begin
            state_nxt = ST_READ;
            tmr_val   = ACC_LD;
          end
        end
      end
      ST_TURN: begin
        if (tmr_done) begin
          state_nxt = ST_WRITE;
          tmr_load  = 1'b1;
          tmr_val   = WP_LD;
        end
      end
      ST_WRITE: begin
        if (tmr_done) begin
          if (WR_PAD > 0) begin
            state_nxt = ST_PAD;
            tmr_load  = 1'b1;
            tmr_val   = WRP_LD;
          end else begin
            state_nxt = ST_IDLE;
          end
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          cap_fire = 1'b1;
          if (RD_PAD > 0) begin
            state_nxt = ST_PAD;
            tmr_load  = 1'b1;
            tmr_val   = RDP_LD;
          end else begin
            state_nxt = ST_IDLE;
          end
        end
      end
      ST_PAD: begin
        if (tmr_done) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      owe_turn <= 1'b0;
    end else begin
      state <= state_nxt;
      if (cap_fire)
        owe_turn <= 1'b1;
      else if (state_nxt == ST_WRITE)
        owe_turn <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_t    state_nxt,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap_fire,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic nxt_wr, nxt_rd;

  assign nxt_wr = (state_nxt == ST_WRITE);
  assign nxt_rd = (state_nxt == ST_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n  <= !(nxt_wr || nxt_rd);
      mem_we_n  <= !nxt_wr;
      mem_oe_n  <= !nxt_rd;
      mem_dq_oe <= nxt_wr;
      rsp_valid <= cap_fire;
      if (cap_fire) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned AW            = 15,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_NS        = 10,
  parameter int unsigned ACCESS_NS     = 10,
  parameter int unsigned WR_PULSE_NS   = 8,
  parameter int unsigned DATA_SETUP_NS = 7,
  parameter int unsigned RELEASE_NS    = 5,
  parameter int unsigned CYCLE_NS      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int unsigned ACC_CYC = ns_to_cyc(ACCESS_NS, CLK_NS);
  localparam int unsigned WP_CYC  = max_u(ns_to_cyc(WR_PULSE_NS, CLK_NS),
                                          ns_to_cyc(DATA_SETUP_NS, CLK_NS));
  localparam int unsigned TA_CYC  = ns_to_cyc(RELEASE_NS, CLK_NS);
  localparam int unsigned CYC_CYC = ns_to_cyc(CYCLE_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max_u(max_u(ACC_CYC, WP_CYC), max_u(TA_CYC, CYC_CYC));
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  // Named internal events, visible to the bound checker.
  logic          op_accept;
  logic          rd_capture;
  logic          tmr_load;
  logic          tmr_done;
  logic [CW-1:0] tmr_val;
  seq_state_t    state_nxt;

  sram_seq_fsm #(
    .WP_CYC (WP_CYC),
    .ACC_CYC(ACC_CYC),
    .TA_CYC (TA_CYC),
    .CYC_CYC(CYC_CYC),
    .CW     (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .tmr_done (tmr_done),
    .ready    (req_ready),
    .accept   (op_accept),
    .cap_fire (rd_capture),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .state_nxt(state_nxt)
  );

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  sram_seq_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_nxt (state_nxt),
    .accept    (op_accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cap_fire  (rd_capture),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_seq_checks.sv
module sram_seq_checks #(
  parameter int unsigned WP_CYC = 1,
  parameter int unsigned TA_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic op_accept,
  input logic rd_capture,
  input logic mem_ce_n,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic mem_dq_oe,
  input logic rsp_valid
);

  int unsigned we_run;
  int unsigned since_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run   <= 0;
      since_oe <= TA_CYC;
    end else begin
      if (!mem_we_n) we_run <= (we_run < WP_CYC) ? we_run + 1 : we_run;
      else           we_run <= 0;
      if (!mem_oe_n)            since_oe <= 0;
      else if (since_oe < TA_CYC) since_oe <= since_oe + 1;
    end
  end

  a_r8_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  a_r8_drive_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

  a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n));

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r7_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |-> req_ready);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r3_reply_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_oe_n && $past(!mem_oe_n) && $past(rd_capture)));

  a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= WP_CYC));

  a_r6_turnaround_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_oe >= TA_CYC));

endmodule

bind sram_seq_ctrl sram_seq_checks #(
  .WP_CYC(WP_CYC),
  .TA_CYC(TA_CYC)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .op_accept (op_accept),
  .rd_capture(rd_capture),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .rsp_valid (rsp_valid)
);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;

  localparam int CLK_NS = 10;
  localparam int T_ACC  = 25;
  localparam int T_WP   = 18;
  localparam int T_DS   = 7;
  localparam int T_REL  = 15;
  localparam int T_CYC  = 40;

  // R4: bench-side cycle arithmetic
  function automatic int cyc_of(input int ns);
    int q;
    q = ns / CLK_NS;
    if (ns % CLK_NS != 0) q = q + 1;
    if (q < 1) q = 1;
    return q;
  endfunction

  localparam int E_ACC = cyc_of(T_ACC);
  localparam int E_WP  = (cyc_of(T_WP) > cyc_of(T_DS)) ? cyc_of(T_WP) : cyc_of(T_DS);
  localparam int E_TA  = cyc_of(T_REL);
  localparam int E_CYC = cyc_of(T_CYC);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  always #5 clk = ~clk;

  sram_seq_ctrl #(
    .CLK_NS(CLK_NS), .ACCESS_NS(T_ACC), .WR_PULSE_NS(T_WP),
    .DATA_SETUP_NS(T_DS), .RELEASE_NS(T_REL), .CYCLE_NS(T_CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int clash    = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------- behavioural memory responder ----------
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  int rd_age  = 0;
  int rel_hold = 0;

  function automatic logic [7:0] blank_of(input logic [14:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] ram_get(input logic [14:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : blank_of(a);
  endfunction

  wire reading = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = (reading && rd_age >= E_ACC) ? ram_get(mem_addr) : 8'hEE;

  always @(negedge clk) begin
    if ((reading || rel_hold > 0) && mem_dq_oe) clash++;
    if (reading) begin
      rd_age   <= rd_age + 1;
      rel_hold <= E_TA;
    end else begin
      rd_age <= 0;
      if (rel_hold > 0) rel_hold <= rel_hold - 1;
    end
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) ram[int'(mem_addr)] = mem_dq_out;
  end

  // ---------- scoreboard monitor ----------
  logic [7:0] exp_q [$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected response", rsp_rdata, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R3 read data", rsp_rdata, e);
      end
    end
  end

  // ---------- driver ----------
  bit last_rd = 1'b0;

  task automatic run_op(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit spam);
    int lead = 0, busy = 0, we_low = 0, oe_low = 0;
    bit seen = 1'b0;
    bit owe;
    int phase, exp_lead;
    owe = wr && last_rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : blank_of(a));
    forever begin
      @(negedge clk);
      if (req_ready) break;
      if (spam) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 15'h1; req_wdata = ~d;
      end else begin
        req_valid = 1'b0;
      end
      busy++;
      if (!seen && mem_ce_n) lead++;
      if (!seen && !mem_ce_n) begin
        seen = 1'b1;
        if (wr)
          chk(mem_addr == a && mem_dq_out == d && !mem_we_n && mem_oe_n && mem_dq_oe,
              "R2 write pins", {mem_addr, mem_dq_out}, {a, d});
        else
          chk(mem_addr == a && !mem_oe_n && mem_we_n && !mem_dq_oe,
              "R3 read pins", mem_addr, a);
      end
      if (!mem_we_n) we_low++;
      if (!mem_oe_n) oe_low++;
    end
    req_valid = 1'b0;
    phase    = wr ? E_WP : E_ACC;
    exp_lead = owe ? E_TA : 0;
    if (wr) chk(lead == exp_lead, "R6 turnaround cycles", lead, exp_lead);
    else    chk(lead == 0, "R10 read starts at once", lead, 0);
    chk(busy == exp_lead + ((phase > E_CYC) ? phase : E_CYC), "R5 busy length", busy,
        exp_lead + ((phase > E_CYC) ? phase : E_CYC));
    if (wr) chk(we_low == E_WP && oe_low == 0, "R2 strobe cycles (R4 count)", we_low, E_WP);
    else    chk(oe_low == E_ACC && we_low == 0, "R3 access cycles (R4 count)", oe_low, E_ACC);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R9 idle pins",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    last_rd = !wr;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1 reset state", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !rsp_valid, "R1 after reset", req_ready, 1);

    run_op(1'b1, 15'h0010, 8'h3C, 1'b0);
    run_op(1'b0, 15'h0010, 8'h00, 1'b0);   // R10 read after write
    run_op(1'b1, 15'h7FFF, 8'hC3, 1'b0);   // R6 write after read
    run_op(1'b0, 15'h0000, 8'h00, 1'b0);
    run_op(1'b0, 15'h7FFF, 8'h00, 1'b0);
    run_op(1'b1, 15'h1234, 8'h81, 1'b1);   // R7 spam during busy
    run_op(1'b0, 15'h1235, 8'h00, 1'b0);
    run_op(1'b0, 15'h1234, 8'h00, 1'b0);
    for (int i = 0; i < 4; i++) run_op(1'b1, 15'(16'h0400 + i), 8'(8'h10 * i + 7), 1'b0);
    for (int i = 0; i < 4; i++) run_op(1'b0, 15'(16'h0400 + i), 8'h00, 1'b0);

    repeat (4) @(negedge clk);
    chk(!ram.exists(int'(15'h1235)), "R7 busy request not written", ram.exists(int'(15'h1235)), 0);
    chk(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
    chk(clash == 0, "R8 no bus contention", clash, 0);
    done_flag = 1'b1;
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

endmodule